// File: doc/BRIEF.md
# Converter Calibration Start-Up Sequencer

This block is the control sequencer that sits beside a self-calibrating successive-approximation converter. It decides when a calibration pass starts, how long it runs, and when a conversion may begin. A full calibration can be started in two ways. One is an external reset pin, which is synchronized and must stay high long enough to count as a real reset. The other is a software pattern on the host bus: chip select, the address bit and the hold request all low in the same cycle.

While reset is held, or while calibration runs, the block reports itself busy on the end-of-conversion and end-of-transfer flags. Hold requests are ignored during that time and during the acquisition window that follows. After that window the block waits in a ready state for a hold request. It then runs a conversion, modelled here as a fixed-length delay. In standalone wiring (chip select and read strobe low, address bit high), calibration completion is reported differently. The end-of-conversion flag stays high, and end-of-transfer drops a fixed number of cycles later. A one-cycle calibration-done pulse and a ready level are provided for an interrupt controller.

Top module: `adc_cal_seq`

## Requirements
- R1: The reset pin passes through a two-stage synchronizer. It counts as a reset only after its synchronized level has been high for RST_MIN_CYC consecutive cycles, where RST_MIN_CYC = ceil(RST_MIN_NS / clock period). A shorter pulse changes neither the state nor the flags.
- R2: The state is reported on `seq_state` with these codes: 0 idle/reset, 1 calibrate, 2 acquire, 3 ready, 4 convert. After the system reset `rst`, and while a qualified pin reset is held, the state is 0, `eoc`=1, `eot`=1, `ready`=0 and `cal_done`=0.
- R3: When a qualified pin reset is released, the state becomes calibrate. Calibration lasts exactly CAL_CYCLES cycles and then moves to acquire.
- R4: Reset takes priority over everything else. A pin reset or a software reset that arrives during a conversion or a calibration aborts it, and a new calibration of full length follows.
- R5: A software reset is cs_n=0, a0=0 and hold_n=0 sampled in the same cycle. Two rising edges later the state is calibrate with its cycle count restarted. When cs_n=0 and a0=0 but hold_n=1, nothing happens.
- R6: `eoc` is high in the idle/reset and calibrate states. In bus mode, `eoc` and `eot` both go low in the first acquire cycle.
- R7: The acquire state lasts exactly ACQ_FIXED_CYCLES + ceil(ACQ_TIME_NS / clock period) cycles. A hold request (hold_n=0) that is present during idle/reset, calibrate or acquire does not start a conversion.
- R8: Standalone mode is cs_n=0, rd_n=0 and a0=1 at calibration completion. In this mode `eoc` stays high after calibration, and `eot` first reads low EOT_DELAY cycles after the first acquire cycle. `eoc` then falls when the first conversion ends.
- R9: `cal_done` is high for exactly one cycle per completed calibration, in the first acquire cycle. `ready` is high exactly while the state is ready.
- R10: In the ready state, hold_n=0 that is not a software-reset pattern enters convert two edges later. Convert lasts CONV_CYCLES cycles with `eoc`=1 and `ready`=0, and then returns to ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| reset_pin | input | 1 | Asynchronous external reset request |
| cs_n | input | 1 | Chip select, active low |
| a0 | input | 1 | Address bit |
| rd_n | input | 1 | Read strobe, active low |
| hold_n | input | 1 | Hold/convert request, active low |
| eoc | output | 1 | End-of-conversion flag, high while busy |
| eot | output | 1 | End-of-transfer flag |
| cal_done | output | 1 | One-cycle calibration completion pulse |
| ready | output | 1 | High while a hold request would be accepted |
| seq_state | output | 3 | Current sequencer state code |

## Verification
Embedded assertions check the following on every cycle: a held reset forces the idle state, a software reset restarts calibration, acquire is entered only from calibrate and convert only from ready, `eoc` is high in busy states, and `cal_done` lasts a single cycle. Other properties need whole scenarios, so only the bench can show them. These are the exact lengths of calibrate, acquire and convert with a shortened calibration. They also include the pulse-width threshold of the pin filter, the abort of a conversion or calibration, and the delayed `eot` fall in standalone wiring.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE_RESET = 3'd0,
    ST_CALIBRATE  = 3'd1,
    ST_ACQUIRE    = 3'd2,
    ST_READY      = 3'd3,
    ST_CONVERT    = 3'd4
  } seq_state_e;
endpackage

// File: rtl/pin_reset_filter.sv
module pin_reset_filter #(
  parameter int MIN_HIGH = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic hold_o,
  output logic release_o
);
  localparam int W = $clog2(MIN_HIGH + 1);
  localparam logic [W-1:0] LAST = W'(MIN_HIGH - 1);
  localparam logic [W-1:0] TOP  = W'(MIN_HIGH);

  logic         sync1, sync2;
  logic [W-1:0] high_cnt;
  logic         qual;
  logic         rel;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1    <= 1'b0;
      sync2    <= 1'b0;
      high_cnt <= '0;
      qual     <= 1'b0;
      rel      <= 1'b0;
    end else begin
      sync1 <= pin;
      sync2 <= sync1;
      if (sync2) begin
        if (high_cnt != TOP) high_cnt <= high_cnt + 1'b1;
      end else begin
        high_cnt <= '0;
      end
      if (!sync2)
        qual <= 1'b0;
      else if (high_cnt == LAST)
        qual <= 1'b1;
      rel <= qual && !sync2;
    end
  end

  assign hold_o    = qual;
  assign release_o = rel;

  AST_HOLD_DROPS_WITH_PIN: assert property (@(posedge clk) disable iff (rst) (qual && !sync2) |=> !qual); // R1
  AST_RELEASE_FOLLOWS_HOLD: assert property (@(posedge clk) disable iff (rst) rel |-> $past(qual)); // R1
  AST_QUAL_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst) $rose(qual) |-> $past(sync2)); // R1
endmodule

// File: rtl/bus_decoder.sv
module bus_decoder (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic a0,
  input  logic rd_n,
  input  logic hold_n,
  output logic sw_rst_o,
  output logic conv_req_o,
  output logic standalone_o
);
  logic sw_pat;

  always_comb sw_pat = !cs_n && !a0 && !hold_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_rst_o     <= 1'b0;
      conv_req_o   <= 1'b0;
      standalone_o <= 1'b0;
    end else begin
      sw_rst_o     <= sw_pat;
      conv_req_o   <= !hold_n && !sw_pat;
      standalone_o <= !cs_n && !rd_n && a0;
    end
  end

  AST_SW_NEEDS_LOW_ADDR: assert property (@(posedge clk) disable iff (rst) sw_rst_o |-> $past(!a0 && !cs_n)); // R5
endmodule

// File: rtl/seq_core.sv
module seq_core
  import adc_seq_pkg::*;
#(
  parameter int CAL_CYCLES  = 1441020,
  parameter int ACQ_CYCLES  = 288,
  parameter int CONV_CYCLES = 64,
  parameter int EOT_DELAY   = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rst_hold,
  input  logic       rst_rel,
  input  logic       sw_rst,
  input  logic       conv_req,
  input  logic       standalone,
  output seq_state_e state,
  output logic       eoc,
  output logic       eot,
  output logic       cal_done,
  output logic       ready
);
  localparam int MAXA  = (CAL_CYCLES > ACQ_CYCLES) ? CAL_CYCLES : ACQ_CYCLES;
  localparam int MAXC  = (MAXA > CONV_CYCLES) ? MAXA : CONV_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int ED_W  = $clog2(EOT_DELAY + 1);
  localparam logic [CNT_W-1:0] CAL_LAST  = CNT_W'(CAL_CYCLES - 1);
  localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(ACQ_CYCLES - 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);
  localparam logic [ED_W-1:0]  EOT_LAST  = ED_W'(EOT_DELAY - 1);

  seq_state_e       state_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             restart;
  logic             cal_fin, conv_fin, busy_n, early_n;
  logic             sa_eoc;
  logic             eot_pend;
  logic [ED_W-1:0]  eot_cnt;

  always_comb begin
    state_n = state;
    restart = 1'b0;
    unique case (state)
      ST_IDLE_RESET: state_n = ST_IDLE_RESET;
      ST_CALIBRATE:  if (cnt == CAL_LAST)  state_n = ST_ACQUIRE;
      ST_ACQUIRE:    if (cnt == ACQ_LAST)  state_n = ST_READY;
      ST_READY:      if (conv_req)         state_n = ST_CONVERT;
      ST_CONVERT:    if (cnt == CONV_LAST) state_n = ST_READY;
      default:       state_n = ST_IDLE_RESET;
    endcase
    if (rst_hold) begin
      state_n = ST_IDLE_RESET;
    end else if (rst_rel || sw_rst) begin
      state_n = ST_CALIBRATE;
      restart = 1'b1;
    end
  end

  always_comb begin
    if (restart || state_n != state)
      cnt_n = '0;
    else if (state == ST_CALIBRATE || state == ST_ACQUIRE || state == ST_CONVERT)
      cnt_n = cnt + 1'b1;
    else
      cnt_n = cnt;
  end

  always_comb begin
    cal_fin  = (state == ST_CALIBRATE) && (state_n == ST_ACQUIRE);
    conv_fin = (state == ST_CONVERT) && (state_n == ST_READY);
    early_n  = (state_n == ST_IDLE_RESET) || (state_n == ST_CALIBRATE);
    busy_n   = early_n || (state_n == ST_CONVERT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE_RESET;
      cnt   <= '0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eoc      <= 1'b1;
      sa_eoc   <= 1'b0;
      cal_done <= 1'b0;
      ready    <= 1'b0;
    end else begin
      eoc      <= busy_n || (cal_fin && standalone) || (sa_eoc && !conv_fin && !early_n);
      cal_done <= cal_fin;
      ready    <= (state_n == ST_READY);
      if (early_n)       sa_eoc <= 1'b0;
      else if (cal_fin)  sa_eoc <= standalone;
      else if (conv_fin) sa_eoc <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eot      <= 1'b1;
      eot_pend <= 1'b0;
      eot_cnt  <= '0;
    end else if (early_n) begin
      eot      <= 1'b1;
      eot_pend <= 1'b0;
      eot_cnt  <= '0;
    end else if (cal_fin) begin
      eot      <= standalone;
      eot_pend <= standalone;
      eot_cnt  <= '0;
    end else if (eot_pend) begin
      eot_cnt <= eot_cnt + 1'b1;
      if (eot_cnt == EOT_LAST) begin
        eot      <= 1'b0;
        eot_pend <= 1'b0;
      end
    end
  end

  AST_HOLD_FORCES_IDLE: assert property (@(posedge clk) disable iff (rst) rst_hold |=> state == ST_IDLE_RESET); // R4
  AST_SW_RESTARTS_CAL: assert property (@(posedge clk) disable iff (rst) (sw_rst && !rst_hold) |=> (state == ST_CALIBRATE && cnt == '0)); // R5
  AST_CAL_RUNS_FULL: assert property (@(posedge clk) disable iff (rst) (state == ST_CALIBRATE && cnt == CAL_LAST && !rst_hold && !rst_rel && !sw_rst) |=> state == ST_ACQUIRE); // R3
  AST_ACQ_FROM_CAL: assert property (@(posedge clk) disable iff (rst) $rose(state == ST_ACQUIRE) |-> $past(state) == ST_CALIBRATE); // R3
  AST_CONV_ONLY_FROM_READY: assert property (@(posedge clk) disable iff (rst) $rose(state == ST_CONVERT) |-> $past(state) == ST_READY); // R7
  AST_EOC_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst) (state == ST_IDLE_RESET || state == ST_CALIBRATE || state == ST_CONVERT) |-> eoc); // R6
  AST_CAL_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) cal_done |=> !cal_done); // R9
  AST_READY_MATCHES: assert property (@(posedge clk) disable iff (rst) ready |-> state == ST_READY); // R9
endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
  import adc_seq_pkg::*;
#(
  parameter int CLK_PERIOD_PS    = 8000,
  parameter int RST_MIN_NS       = 100,
  parameter int ACQ_TIME_NS      = 2250,
  parameter int ACQ_FIXED_CYCLES = 6,
  parameter int CAL_CYCLES       = 1441020,
  parameter int CONV_CYCLES      = 64,
  parameter int EOT_DELAY        = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reset_pin,
  input  logic       cs_n,
  input  logic       a0,
  input  logic       rd_n,
  input  logic       hold_n,
  output logic       eoc,
  output logic       eot,
  output logic       cal_done,
  output logic       ready,
  output logic [2:0] seq_state
);
  localparam int RST_MIN_CYC  = (RST_MIN_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int ACQ_TIME_CYC = (ACQ_TIME_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int ACQ_CYCLES   = ACQ_FIXED_CYCLES + ACQ_TIME_CYC;

  logic       rst_hold, rst_rel;
  logic       sw_rst, conv_req, standalone;
  seq_state_e st;

  pin_reset_filter #(.MIN_HIGH(RST_MIN_CYC)) u_pin (
    .clk       (clk),
    .rst       (rst),
    .pin       (reset_pin),
    .hold_o    (rst_hold),
    .release_o (rst_rel)
  );

  bus_decoder u_bus (
    .clk          (clk),
    .rst          (rst),
    .cs_n         (cs_n),
    .a0           (a0),
    .rd_n         (rd_n),
    .hold_n       (hold_n),
    .sw_rst_o     (sw_rst),
    .conv_req_o   (conv_req),
    .standalone_o (standalone)
  );

  seq_core #(
    .CAL_CYCLES  (CAL_CYCLES),
    .ACQ_CYCLES  (ACQ_CYCLES),
    .CONV_CYCLES (CONV_CYCLES),
    .EOT_DELAY   (EOT_DELAY)
  ) u_core (
    .clk        (clk),
    .rst        (rst),
    .rst_hold   (rst_hold),
    .rst_rel    (rst_rel),
    .sw_rst     (sw_rst),
    .conv_req   (conv_req),
    .standalone (standalone),
    .state      (st),
    .eoc        (eoc),
    .eot        (eot),
    .cal_done   (cal_done),
    .ready      (ready)
  );

  assign seq_state = st;
endmodule

// File: tb/adc_cal_seq_bench.sv
module adc_cal_seq_bench;
  localparam int CAL  = 40;
  localparam int ACQ  = 10;
  localparam int CONV = 8;
  localparam int EOTD = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reset_pin = 1'b0;
  logic cs_n = 1'b1, a0 = 1'b1, rd_n = 1'b1, hold_n = 1'b1;
  logic eoc, eot, cal_done, ready;
  logic [2:0] seq_state;

  int total = 0;
  int bad = 0;
  int cd_cnt = 0;
  int eoc_viol = 0;

  always #4 clk = ~clk;

  adc_cal_seq #(
    .CLK_PERIOD_PS(8000), .RST_MIN_NS(30), .ACQ_TIME_NS(30), .ACQ_FIXED_CYCLES(6),
    .CAL_CYCLES(CAL), .CONV_CYCLES(CONV), .EOT_DELAY(EOTD)
  ) u_adc_cal_seq (
    .clk(clk), .rst(rst), .reset_pin(reset_pin), .cs_n(cs_n), .a0(a0), .rd_n(rd_n),
    .hold_n(hold_n), .eoc(eoc), .eot(eot), .cal_done(cal_done), .ready(ready),
    .seq_state(seq_state)
  );

  always @(negedge clk) begin
    if (!rst && cal_done) cd_cnt++;
    if (!rst && (seq_state == 3'd0 || seq_state == 3'd1) && !eoc) eoc_viol++;
  end

  // {cs_n, a0, rd_n, hold_n, expected state}, applied in the ready state
  localparam logic [6:0] VEC [6] = '{
    {4'b1111, 3'd3}, {4'b1110, 3'd4}, {4'b0110, 3'd4},
    {4'b0011, 3'd3}, {4'b0010, 3'd1}, {4'b0101, 3'd3}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_idle();
    cs_n = 1'b1; a0 = 1'b1; rd_n = 1'b1; hold_n = 1'b1;
  endtask

  task automatic wait_state(input logic [2:0] s, input string req);
    int n = 0;
    while (seq_state != s && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(seq_state == s, req, seq_state, s);
  endtask

  task automatic measure(input logic [2:0] s, output int n);
    n = 0;
    while (seq_state == s && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int k;
    bit stay;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2: state after system reset
    chk(seq_state == 3'd0, "R2 state", seq_state, 0);
    chk(eoc && eot && !ready && !cal_done, "R2 flags", {eoc, eot, ready, cal_done}, 4'b1100);

    // R1, R2: held pin reset
    reset_pin = 1'b1;
    repeat (8) @(negedge clk);
    chk(seq_state == 3'd0 && eoc && eot && !ready, "R2 held", seq_state, 0);
    reset_pin = 1'b0;
    wait_state(3'd1, "R3 enter cal");
    hold_n = 1'b0;  // R7: hold ignored while calibrating
    measure(3'd1, n);
    chk(n == CAL, "R3 cal length", n, CAL);
    chk(seq_state == 3'd2, "R3 to acquire", seq_state, 2);
    chk(cal_done == 1'b1, "R9 cal_done", cal_done, 1);
    chk(!eoc && !eot, "R6 flags fall", {eoc, eot}, 0);
    measure(3'd2, n);
    chk(n == ACQ, "R7 acquire length", n, ACQ);
    chk(seq_state == 3'd3 && ready, "R9 ready", seq_state, 3);
    hold_n = 1'b1;
    @(negedge clk);
    chk(seq_state == 3'd4 && eoc && !ready, "R10 convert", seq_state, 4);
    measure(3'd4, n);
    chk(n == CONV, "R10 convert length", n, CONV);
    chk(seq_state == 3'd3 && !eoc, "R10 back ready", seq_state, 3);
    chk(cd_cnt == 1, "R9 single pulse", cd_cnt, 1);

    // R5, R10: bus pattern table
    foreach (VEC[i]) begin
      {cs_n, a0, rd_n, hold_n} = VEC[i][6:3];
      @(posedge clk);
      @(negedge clk);
      bus_idle();
      @(posedge clk);
      @(negedge clk);
      chk(seq_state == VEC[i][2:0], "R5 R10 vector", seq_state, VEC[i][2:0]);
      chk(ready == (VEC[i][2:0] == 3'd3), "R9 ready vector", ready, VEC[i][2:0] == 3'd3);
      wait_state(3'd3, "R10 return ready");
    end

    // R4, R5: software reset aborts a conversion
    hold_n = 1'b0;
    @(negedge clk);
    hold_n = 1'b1;
    @(negedge clk);
    chk(seq_state == 3'd4, "R10 conv start", seq_state, 4);
    cs_n = 1'b0; a0 = 1'b0; hold_n = 1'b0;
    @(negedge clk);
    bus_idle();
    @(negedge clk);
    chk(seq_state == 3'd1, "R4 sw abort", seq_state, 1);
    measure(3'd1, n);
    chk(n == CAL, "R5 full cal after sw", n, CAL);
    wait_state(3'd3, "R5 ready");

    // R8: standalone wiring
    cs_n = 1'b0; a0 = 1'b0; hold_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b0; a0 = 1'b1; rd_n = 1'b0; hold_n = 1'b1;
    wait_state(3'd2, "R8 acquire");
    chk(eoc && eot, "R8 flags held", {eoc, eot}, 3);
    k = 0;
    while (eot && k < 100) begin
      @(negedge clk);
      k++;
    end
    chk(k == EOTD, "R8 eot delay", k, EOTD);
    wait_state(3'd3, "R8 ready");
    chk(eoc == 1'b1, "R8 eoc stays", eoc, 1);
    hold_n = 1'b0;
    @(negedge clk);
    hold_n = 1'b1;
    wait_state(3'd4, "R8 convert");
    wait_state(3'd3, "R8 ready again");
    chk(eoc == 1'b0, "R8 eoc falls", eoc, 0);
    bus_idle();

    // R1: short pulse ignored
    reset_pin = 1'b1;
    repeat (3) @(negedge clk);
    reset_pin = 1'b0;
    stay = 1'b1;
    repeat (12) begin
      @(negedge clk);
      if (seq_state != 3'd3 || !ready) stay = 1'b0;
    end
    chk(stay, "R1 short pulse", stay, 1);

    // R1, R4: minimum pulse aborts calibration
    cs_n = 1'b0; a0 = 1'b0; hold_n = 1'b0;
    @(negedge clk);
    bus_idle();
    wait_state(3'd1, "R4 cal");
    repeat (10) @(negedge clk);
    reset_pin = 1'b1;
    repeat (4) @(negedge clk);
    reset_pin = 1'b0;
    wait_state(3'd0, "R1 min pulse");
    wait_state(3'd1, "R4 recal");
    measure(3'd1, n);
    chk(n == CAL, "R4 full recal", n, CAL);
    chk(eoc_viol == 0, "R6 eoc busy", eoc_viol, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule